// File: doc/BRIEF.md
# Flash Bank Erase and Program Sequencer

This block erases or programs one bank of a byte-wide flash device whose erase and program commands are guarded by a two-write unlock prefix. A request is a one-cycle `start` pulse together with an operation select and a bank number. The block then writes the command sequence to the flash. Between any two of its writes it leaves a programmable number of idle cycles. It detects completion by reading the bank base twice and comparing the two reads: while the device works, one of its data bits toggles on every read.

Programming fetches each byte from a source array through a combinational read port indexed by bank offset. The bank is programmed in ascending offset order. When the erase or the last byte finishes, or the poll gives up, the block writes the read-mode command to the bank base. If the operation did not time out, it then reads the whole bank back to verify it. The result is reported with a one-cycle `done` pulse and a status code.

The flash address is `{bank, offset}`, with the offset in the low `OFS_W` bits (at least 11 bits, so that the unlock offsets fit). Flash read data is expected on `fl_rdata` in the cycle after `fl_re`.

Top module: `flash_bank_sequencer`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `busy`, `done`, `fl_we` and `fl_re` are all 0.
- R2: Every erase command and every per-byte program command begins with the unlock prefix: 0xAA written to bank offset 0x555, then 0x55 written to bank offset 0x2AA.
- R3: An erase (`op`=0) writes, in this order:
  - the prefix;
  - 0x80 at offset 0x555;
  - the prefix again;
  - 0x30 at offset 0.

  Counting the final read-mode write, that is exactly 7 writes. Afterwards every byte of the selected bank reads 0xFF, and the other bank is unchanged.
- R4: A program operation (`op`=1) handles offsets 0 to `BANK_BYTES`-1 in ascending order. For each byte it writes the prefix, then 0xA0 at offset 0x555, then the source byte at that offset, and polls before the next byte. That is 4·`BANK_BYTES`+1 writes in all, and the bank then equals the source.
- R5: Between any two writes there are at least `GAP_CYC` cycles in which `fl_we` is low.
- R6: After the last write of a command, the block reads bank offset 0 in pairs. It continues only when the two reads of a pair are equal, so it never writes while the device is still busy. `fl_we` and `fl_re` are never high in the same cycle.
- R7: After `POLL_MAX` unequal pairs for one command, the operation ends with status 1 (timeout). No further program byte is issued after a timeout.
- R8: The last write of every operation, including one that timed out, is 0xF0 at bank offset 0.
- R9: After the read-mode write of an operation that did not time out, the block reads every offset of the bank, from 0 upward.
  - Erase expects 0xFF at every offset; programming expects the source byte.
  - The first mismatch ends the operation with status 2.
  - A timed-out operation skips this readback.
- R10: `busy` rises in the cycle after an accepted `start` and stays high through a one-cycle `done` pulse. A `start` while `busy` is high is ignored.
- R11: `status` is valid in the `done` cycle. Code 0 means the operation finished and verified correctly, and code 3 never occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| op | input | 1 | 0 = erase bank, 1 = program bank |
| bank | input | BANK_W | Bank selected by the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 verify mismatch |
| src_addr | output | OFS_W | Offset of the source byte wanted |
| src_data | input | 8 | Source byte at `src_addr`, same cycle |
| fl_addr | output | BANK_W+OFS_W | Flash address `{bank, offset}` |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_re` |

## Verification
The assertions check on every cycle the behaviours that need no memory contents:
- the idle spacing between writes;
- reads and writes never overlapping;
- the read-mode write being the last write before `done`;
- the one-cycle `done` pulse that ends `busy`;
- `busy` rising only after a `start`;
- the bound on the poll miss counter.

Only the bench scenarios can show the rest, using a flash model that decodes the unlock sequences and toggles a bit while busy. That covers the exact command order and write counts, the resulting bank contents and the untouched neighbour bank. It also covers the timeout path with a device that never settles, verify failures injected into erase and program, and a second request ignored mid-operation.

// File: rtl/fbs_pkg.sv
// Shared types and command constants of the flash bank sequencer.
// Assumes byte-wide flash with a two-write unlock prefix.
package fbs_pkg;
    typedef enum logic {OP_ERASE = 1'b0, OP_PROG = 1'b1} op_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_TIMEOUT  = 2'd1,
        ST_MISMATCH = 2'd2
    } status_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_GAP, S_RD1, S_RD2, S_CHK,
        S_RSTW, S_VRD, S_VCHK, S_DONE
    } state_e;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] ERASE_ARM   = 8'h80;
    localparam logic [7:0] ERASE_FIRE  = 8'h30;
    localparam logic [7:0] PROG_ARM    = 8'hA0;
    localparam logic [7:0] READ_MODE   = 8'hF0;
    localparam int         KEY_OFS_A   = 'h555;
    localparam int         KEY_OFS_B   = 'h2AA;
endpackage

// File: rtl/fbs_cmd_table.sv
// Command step decoder: maps operation and step index to the offset and
// byte of one command write. Erase uses steps 0..5, program uses 0..3.
// Assumes OFS_W >= 11 so the unlock offsets are representable.
module fbs_cmd_table
    import fbs_pkg::*;
#(
    parameter int OFS_W = 13
) (
    input  logic             op_prog,
    input  logic [2:0]       step,
    input  logic [OFS_W-1:0] tgt_ofs,
    input  logic [7:0]       tgt_byte,
    output logic [OFS_W-1:0] cmd_ofs,
    output logic [7:0]       cmd_byte,
    output logic             cmd_last
);
    // Select the write belonging to the current step.
    always_comb begin
        cmd_ofs  = OFS_W'(KEY_OFS_A);
        cmd_byte = KEY_FIRST;
        cmd_last = 1'b0;
        case (step)
            3'd1: begin
                cmd_ofs  = OFS_W'(KEY_OFS_B);
                cmd_byte = KEY_SECOND;
            end
            3'd2: cmd_byte = op_prog ? PROG_ARM : ERASE_ARM;
            3'd3: if (op_prog) begin
                cmd_ofs  = tgt_ofs;
                cmd_byte = tgt_byte;
                cmd_last = 1'b1;
            end
            3'd4: begin
                cmd_ofs  = OFS_W'(KEY_OFS_B);
                cmd_byte = KEY_SECOND;
            end
            3'd5: begin
                cmd_ofs  = '0;
                cmd_byte = ERASE_FIRE;
                cmd_last = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fbs_gap_timer.sv
// Inter-command spacing timer: loaded on every flash write, ready once
// GAP_CYC cycles have elapsed. Assumes GAP_CYC >= 1.
module fbs_gap_timer #(
    parameter int GAP_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic ready
);
    localparam int GW = $clog2(GAP_CYC + 1);

    logic [GW-1:0] cnt_q;

    // Count down the remaining idle cycles after a write.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= GW'(GAP_CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign ready = (cnt_q == '0);

    // R5
    gap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ready);
endmodule

// File: rtl/fbs_toggle_poll.sv
// Toggle poller: holds the first read of a pair, compares it with the
// second, and counts unequal pairs since the last clear.
// Assumes rdata is the flash reply in the cycles cap_first/cap_second.
module fbs_toggle_poll #(
    parameter int POLL_MAX = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cap_first,
    input  logic       cap_second,
    input  logic [7:0] rdata,
    output logic       settled,
    output logic       last_try
);
    localparam int PW = $clog2(POLL_MAX + 1);

    logic [7:0]    first_q;
    logic [PW-1:0] miss_q;

    // Keep the first read of the current pair.
    always_ff @(posedge clk) begin
        if (!rst_n)         first_q <= '0;
        else if (cap_first) first_q <= rdata;
    end

    // Count pairs whose reads differed.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)             miss_q <= '0;
        else if (cap_second && !settled) miss_q <= miss_q + 1'b1;
    end

    assign settled  = ((first_q ^ rdata) == 8'h00);
    assign last_try = (miss_q == PW'(POLL_MAX - 1));

    // R7
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q <= PW'(POLL_MAX));
endmodule

// File: rtl/flash_bank_sequencer.sv
// Top of the flash bank sequencer. Accepts erase/program requests, issues
// unlock-prefixed commands with spacing, polls for completion by toggle
// comparison, returns the device to read mode and verifies by readback.
// Assumes a one-cycle flash read latency and a combinational source port.
module flash_bank_sequencer
    import fbs_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int OFS_W      = 13,
    parameter int BANK_BYTES = 8192,
    parameter int GAP_CYC    = 100,
    parameter int POLL_MAX   = 1_000_000,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int AW        = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic [BANK_W-1:0] bank,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [OFS_W-1:0]  src_addr,
    input  logic [7:0]        src_data,
    output logic [AW-1:0]     fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [7:0]        fl_rdata
);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(BANK_BYTES - 1);
    localparam int               GW       = $clog2(GAP_CYC + 1);

    state_e            state, gap_next;
    op_e               op_q;
    logic [BANK_W-1:0] bank_q;
    logic [2:0]        step_q;
    logic [OFS_W-1:0]  byte_q;
    status_e           status_q;

    logic [OFS_W-1:0]  cmd_ofs;
    logic [7:0]        cmd_byte, exp_byte;
    logic              cmd_last, gap_ready, settled, last_try;

    fbs_cmd_table #(.OFS_W(OFS_W)) u_cmd (
        .op_prog (op_q == OP_PROG),
        .step    (step_q),
        .tgt_ofs (byte_q),
        .tgt_byte(src_data),
        .cmd_ofs (cmd_ofs),
        .cmd_byte(cmd_byte),
        .cmd_last(cmd_last)
    );

    fbs_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .load (fl_we),
        .ready(gap_ready)
    );

    fbs_toggle_poll #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state == S_CMD),
        .cap_first (state == S_RD2),
        .cap_second(state == S_CHK),
        .rdata     (fl_rdata),
        .settled   (settled),
        .last_try  (last_try)
    );

    assign exp_byte = (op_q == OP_PROG) ? src_data : 8'hFF;

    // Sequence the command, poll, reset and verify phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            gap_next <= S_CMD;
            op_q     <= OP_ERASE;
            bank_q   <= '0;
            step_q   <= '0;
            byte_q   <= '0;
            status_q <= ST_OK;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    op_q     <= op_e'(op);
                    bank_q   <= bank;
                    step_q   <= '0;
                    byte_q   <= '0;
                    status_q <= ST_OK;
                    state    <= S_CMD;
                end
                S_CMD: begin
                    state <= S_GAP;
                    if (cmd_last) begin
                        step_q   <= '0;
                        gap_next <= S_RD1;
                    end else begin
                        step_q   <= step_q + 3'd1;
                        gap_next <= S_CMD;
                    end
                end
                S_GAP: if (gap_ready) state <= gap_next;
                S_RD1: state <= S_RD2;
                S_RD2: state <= S_CHK;
                S_CHK: begin
                    if (settled) begin
                        if (op_q == OP_ERASE || byte_q == LAST_OFS) begin
                            state <= S_RSTW;
                        end else begin
                            byte_q <= byte_q + 1'b1;
                            state  <= S_CMD;
                        end
                    end else if (last_try) begin
                        status_q <= ST_TIMEOUT;
                        state    <= S_RSTW;
                    end else begin
                        state <= S_RD1;
                    end
                end
                S_RSTW: begin
                    byte_q   <= '0;
                    state    <= S_GAP;
                    gap_next <= (status_q == ST_TIMEOUT) ? S_DONE : S_VRD;
                end
                S_VRD: state <= S_VCHK;
                S_VCHK: begin
                    if (fl_rdata != exp_byte) begin
                        status_q <= ST_MISMATCH;
                        state    <= S_DONE;
                    end else if (byte_q == LAST_OFS) begin
                        state <= S_DONE;
                    end else begin
                        byte_q <= byte_q + 1'b1;
                        state  <= S_VRD;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the flash strobes, address and data from the current phase.
    always_comb begin
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_wdata = 8'h00;
        fl_addr  = {bank_q, {OFS_W{1'b0}}};
        case (state)
            S_CMD: begin
                fl_we    = 1'b1;
                fl_wdata = cmd_byte;
                fl_addr  = {bank_q, cmd_ofs};
            end
            S_RSTW: begin
                fl_we    = 1'b1;
                fl_wdata = READ_MODE;
            end
            S_RD1, S_RD2: fl_re = 1'b1;
            S_VRD: begin
                fl_re   = 1'b1;
                fl_addr = {bank_q, byte_q};
            end
            default: ;
        endcase
    end

    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);
    assign status   = status_q;
    assign src_addr = byte_q;

    // Checker state: idle cycles since the last write and what it was.
    logic [GW-1:0] since_we;
    logic [7:0]    last_wbyte;
    logic          last_wbase;

    // Track write spacing and the most recent write for the assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_we   <= GW'(GAP_CYC);
            last_wbyte <= READ_MODE;
            last_wbase <= 1'b1;
        end else if (fl_we) begin
            since_we   <= '0;
            last_wbyte <= fl_wdata;
            last_wbase <= (fl_addr[OFS_W-1:0] == '0);
        end else if (since_we != GW'(GAP_CYC)) begin
            since_we <= since_we + 1'b1;
        end
    end

    // R5
    gap_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> since_we == GW'(GAP_CYC));
    // R6
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));
    // R8
    rst_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (last_wbyte == READ_MODE && last_wbase));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R11
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status != 2'd3);
endmodule

// File: tb/sim_flash_bank_sequencer.sv
// Scoreboard bench with a behavioural unlock-sequence flash model.
module sim_flash_bank_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 2;
    localparam int OW         = 13;
    localparam int NBYTES     = 16;
    localparam int IW         = $clog2(NBYTES);
    localparam int GAP        = 3;
    localparam int PMAX       = 20;
    localparam int BUSY_READS = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op = 1'b0;
    logic [0:0]    bank = 1'b0;
    logic          busy, done;
    logic [1:0]    status;
    logic [OW-1:0] src_addr;
    logic [7:0]    src_data;
    logic [OW:0]   fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_we, fl_re;
    logic [7:0]    fl_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_bank_sequencer #(
        .NUM_BANKS(NB), .OFS_W(OW), .BANK_BYTES(NBYTES),
        .GAP_CYC(GAP), .POLL_MAX(PMAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bank(bank),
        .busy(busy), .done(done), .status(status),
        .src_addr(src_addr), .src_data(src_data),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we),
        .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- source array ----------------
    logic [7:0] src [NBYTES];
    assign src_data = (int'(src_addr) < NBYTES) ? src[src_addr[IW-1:0]] : 8'h00;

    // ---------------- flash model ----------------
    logic [7:0]    mem [NB][NBYTES];
    logic [OW-1:0] wofs;
    logic          wbank;
    assign wofs  = fl_addr[OW-1:0];
    assign wbank = fl_addr[OW];

    int   seq = 0, busy_left = 0, since = 100;
    int   wcount = 0, pcount = 0, proto_err = 0, gap_err = 0;
    bit   stuck = 0, corrupt_prog = 0, corrupt_erase = 0, bad;
    int   corrupt_idx = 0;
    logic [7:0]    tog = 8'h00;
    logic [7:0]    last_wdat = 8'h00;
    logic [OW-1:0] last_wofs = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            seq = 0; busy_left = 0; since = 100;
            fl_rdata <= 8'h00;
        end else begin
            if (fl_we) begin
                wcount++;
                if (since < GAP) gap_err++;
                since = 0;
                last_wdat = fl_wdata;
                last_wofs = wofs;
                bad = 0;
                if (fl_wdata == 8'hF0 && wofs == '0) begin
                    seq = 0; busy_left = 0;
                end else if (busy_left > 0) begin
                    proto_err++;
                end else begin
                    case (seq)
                        0: if (wofs == 13'h555 && fl_wdata == 8'hAA) seq = 1; else bad = 1;
                        1: if (wofs == 13'h2AA && fl_wdata == 8'h55) seq = 2; else bad = 1;
                        2: if (wofs == 13'h555 && fl_wdata == 8'h80) seq = 3;
                           else if (wofs == 13'h555 && fl_wdata == 8'hA0) seq = 4;
                           else bad = 1;
                        3: if (wofs == 13'h555 && fl_wdata == 8'hAA) seq = 5; else bad = 1;
                        5: if (wofs == 13'h2AA && fl_wdata == 8'h55) seq = 6; else bad = 1;
                        6: if (wofs == '0 && fl_wdata == 8'h30) begin
                               for (int i = 0; i < NBYTES; i++)
                                   mem[wbank][i] = (corrupt_erase && i == corrupt_idx) ? 8'h7F : 8'hFF;
                               busy_left = BUSY_READS;
                               seq = 0;
                           end else bad = 1;
                        4: begin
                               if (int'(wofs) < NBYTES)
                                   mem[wbank][wofs[IW-1:0]] = mem[wbank][wofs[IW-1:0]] &
                                       ((corrupt_prog && int'(wofs) == corrupt_idx) ? (fl_wdata ^ 8'h01) : fl_wdata);
                               pcount++;
                               busy_left = BUSY_READS;
                               seq = 0;
                           end
                        default: bad = 1;
                    endcase
                end
                if (bad) begin
                    proto_err++;
                    seq = 0;
                end
            end else begin
                since++;
            end
            if (fl_re) begin
                if (busy_left > 0) begin
                    if (wofs != '0) proto_err++;
                    tog = tog ^ 8'h40;
                    fl_rdata <= tog;
                    if (!stuck) busy_left--;
                end else if (int'(wofs) < NBYTES) begin
                    fl_rdata <= mem[wbank][wofs[IW-1:0]];
                end else begin
                    fl_rdata <= 8'hFF;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [1:0] q_st [$];
    int         q_wr [$];
    string      q_tag[$];
    int         finished = 0;

    // Monitor: pop the expected result at each done pulse and compare.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_st.size() == 0) begin
                check(0, "R10 unexpected done", 1, 0);
            end else begin
                logic [1:0] est;
                int         ewr;
                string      etag;
                est  = q_st.pop_front();
                ewr  = q_wr.pop_front();
                etag = q_tag.pop_front();
                check(status == est, {etag, " R11 status"}, int'(status), int'(est));
                check(wcount == ewr, {etag, " R2 write count"}, wcount, ewr);
                check(last_wdat == 8'hF0 && last_wofs == '0, {etag, " R8 final write"},
                      int'(last_wdat), 'hF0);
                check(busy == 1'b1, "R10 busy in done cycle", int'(busy), 1);
            end
            finished++;
        end
    end

    // Driver: push the expectation, issue the request, wait for its end.
    task automatic run_op(input bit o, input bit b, input logic [1:0] st,
                          input int writes, input string tag, input bit intrude);
        int tgt;
        q_st.push_back(st);
        q_wr.push_back(writes);
        q_tag.push_back(tag);
        tgt = finished + 1;
        @(negedge clk);
        wcount = 0; pcount = 0;
        start = 1'b1; op = o; bank = b;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        if (intrude) begin
            repeat (6) @(negedge clk);
            start = 1'b1; op = 1'b0; bank = ~b;
            @(negedge clk);
            start = 1'b0;
        end
        wait (finished == tgt);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R10 done lasts one cycle",
              int'({done, busy}), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", finished, 0);
        summary();
        $finish;
    end

    initial begin
        int errs;
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < NBYTES; i++) mem[b][i] = 8'h5A;
        for (int i = 0; i < NBYTES; i++) src[i] = 8'(i * 7 + 3);

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !fl_we && !fl_re, "R1 reset outputs",
              int'({busy, done, fl_we, fl_re}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fl_we && !fl_re, "R1 first cycle after reset",
              int'({busy, done, fl_we, fl_re}), 0);

        // R3 erase bank 0
        run_op(1'b0, 1'b0, 2'd0, 7, "R3", 1'b0);
        errs = 0;
        for (int i = 0; i < NBYTES; i++) if (mem[0][i] != 8'hFF) errs++;
        check(errs == 0, "R3 erased bank reads FF", errs, 0);
        errs = 0;
        for (int i = 0; i < NBYTES; i++) if (mem[1][i] != 8'h5A) errs++;
        check(errs == 0, "R3 other bank untouched", errs, 0);

        // R4 program bank 0
        run_op(1'b1, 1'b0, 2'd0, 4 * NBYTES + 1, "R4", 1'b0);
        errs = 0;
        for (int i = 0; i < NBYTES; i++) if (mem[0][i] != src[i]) errs++;
        check(errs == 0, "R4 programmed bank equals source", errs, 0);
        check(pcount == NBYTES, "R4 one program command per byte", pcount, NBYTES);

        // R10 program bank 1 with a second start while busy
        run_op(1'b0, 1'b1, 2'd0, 7, "R3", 1'b0);
        for (int i = 0; i < NBYTES; i++) src[i] = 8'(8'hC3 ^ (i * 13));
        run_op(1'b1, 1'b1, 2'd0, 4 * NBYTES + 1, "R4", 1'b1);
        errs = 0;
        for (int i = 0; i < NBYTES; i++) if (mem[1][i] != src[i]) errs++;
        check(errs == 0, "R4 bank 1 equals second pattern", errs, 0);
        errs = 0;
        for (int i = 0; i < NBYTES; i++) if (mem[0][i] != 8'(i * 7 + 3)) errs++;
        check(errs == 0, "R10 start while busy ignored", errs, 0);

        // R7 erase that never settles
        stuck = 1;
        run_op(1'b0, 1'b0, 2'd1, 7, "R7", 1'b0);
        stuck = 0;

        // R7 program that never settles: only the first byte is issued
        stuck = 1;
        run_op(1'b1, 1'b0, 2'd1, 5, "R7", 1'b0);
        stuck = 0;
        check(pcount == 1, "R7 programming stops after timeout", pcount, 1);
        errs = 0;
        for (int i = 1; i < NBYTES; i++) if (mem[0][i] != 8'hFF) errs++;
        check(errs == 0, "R7 later bytes left erased", errs, 0);

        // R9 program verify mismatch
        run_op(1'b0, 1'b0, 2'd0, 7, "R3", 1'b0);
        corrupt_prog = 1; corrupt_idx = 9;
        run_op(1'b1, 1'b0, 2'd2, 4 * NBYTES + 1, "R9", 1'b0);
        corrupt_prog = 0;

        // R9 erase verify mismatch
        corrupt_erase = 1; corrupt_idx = 4;
        run_op(1'b0, 1'b1, 2'd2, 7, "R9", 1'b0);
        corrupt_erase = 0;

        check(proto_err == 0, "R2 R6 protocol errors seen by flash", proto_err, 0);
        check(gap_err == 0, "R5 write spacing violations", gap_err, 0);
        check(q_st.size() == 0, "R10 every request completed", q_st.size(), 0);

        summary();
        $finish;
    end
endmodule